// File: doc/BRIEF.md
# Serial Memory Address-Width Probe

This block is a boot-time SPI master sequencer. After a start pulse it pulls chip select low and sends a read opcode followed by zero bytes. It watches the bytes coming back on MISO, and the first byte position that is not 0xFF tells it whether the attached memory takes two or three address bytes. A line that nobody drives floats high, so an unaddressed memory, or no memory at all, returns 0xFF.

When a standard memory is found, the transaction keeps running. The byte that revealed the width is the content of address zero. The following clocks return the bytes at increasing addresses, and the block delivers a fixed count of them on a valid/ready stream.

When neither width answers, the block releases chip select for one half SCK period. It then reasserts chip select and issues a single status-read command. From the returned status it picks a page size of 256, 528 or 1024 bytes. A status of 0xFF is reported as "no device". The detected kind stays on the outputs until the next start.

Top module: `spi_addr_probe`

## Requirements
- R1: After reset, chip select is high, SCK is low, `busy`, `dev_type_valid` and `rd_valid` are low.
- R2: The first transaction sends 0x03 and then only 0x00 bytes. Each byte goes out MSB first in SPI mode 0: SCK idles low, MOSI changes only while SCK is low, and MISO is sampled on the rising SCK edge.
- R3: Each SCK high and low phase inside a byte lasts `clk_div` system clocks, with 0 treated as 1, so f_SCK = f_clk / (2 * clk_div).
- R4: If the byte received with the fourth transmitted byte (the third 0x00) is not 0xFF, then `dev_type` = 0 (two address bytes) and that byte is stream byte 0.
- R5: If the fourth received byte is 0xFF and the fifth is not 0xFF, then `dev_type` = 1 (three address bytes) and the fifth byte is stream byte 0.
- R6: For a standard device, exactly NBYTES bytes from consecutive addresses are streamed, all within one chip-select-low window. Chip select then rises and `dev_type_valid` goes high.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value and SCK does not toggle.
- R8: If the fifth received byte is also 0xFF, chip select is high for exactly `clk_div` clocks (minimum 1) and is then reasserted. The block sends the status opcode 0xD7 and one 0x00 byte, and the byte received with the 0x00 is the status. Let f = status[5:2]. With `dev_type` = 2, `page_sel` is 0 (256 bytes) when f <= 4, 1 (528 bytes) when f == 5, and 2 (1024 bytes) when f >= 6.
- R9: A status of 0xFF gives `dev_type` = 3 and `page_sel` = 0. `dev_type_valid` is never high while `busy` is high.
- R10: A start pulse while `busy` is high has no effect: no extra chip-select transaction occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a probe (ignored while busy) |
| clk_div | input | DIV_W | SCK half-period in clocks (0 acts as 1) |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from memory (pulled high) |
| dev_type | output | 2 | 0 two-byte, 1 three-byte, 2 paged, 3 none |
| dev_type_valid | output | 1 | Result valid, held until next start |
| busy | output | 1 | Probe or stream in progress |
| page_sel | output | 2 | Paged device size: 0=256, 1=528, 2=1024 |
| rd_data | output | 8 | Streamed memory byte |
| rd_valid | output | 1 | `rd_data` holds a byte |
| rd_ready | input | 1 | Consumer accepts the byte |

## Verification
The bench builds the block with DIV_W = 4 and NBYTES = 4, so a full run lasts a few hundred cycles. This makes it affordable to sweep every divider value from 0 to 3 against a two-byte memory, a three-byte memory, a paged device and an absent device. With the paged device, the bench sweeps all sixteen values of the status size field as well as an all-ones status. A serial memory model in the bench records every MOSI byte per chip-select window, which lets the bench check the opcode sequence, the gap before the status command and the stream contents against an arithmetic memory pattern. Some runs add consumer stalls and spurious start pulses.

// File: rtl/spi_probe_pkg.sv
package spi_probe_pkg;
  typedef enum logic [1:0] {
    DEV_ADDR16 = 2'd0,
    DEV_ADDR24 = 2'd1,
    DEV_PAGED  = 2'd2,
    DEV_NONE   = 2'd3
  } dev_kind_t;

  localparam logic [7:0] READ_OP   = 8'h03;
  localparam logic [7:0] FLOAT_VAL = 8'hFF;

  // page size select from the status size field
  function automatic logic [1:0] page_of(input logic [7:0] status);
    logic [3:0] f;
    f = status[5:2];
    if (f <= 4'd4)      page_of = 2'd0;
    else if (f == 4'd5) page_of = 2'd1;
    else                page_of = 2'd2;
  endfunction
endpackage

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [7:0]       tx_byte,
  input  logic [DIV_W-1:0] div,
  input  logic             miso,
  output logic             busy,
  output logic             done,
  output logic [7:0]       rx_byte,
  output logic             sck,
  output logic             mosi
);
  logic [DIV_W-1:0] lim, cnt;
  logic [7:0]       sr;
  logic [2:0]       bitn;

  assign mosi = sr[7];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; done <= 1'b0; sck <= 1'b0; sr <= '0;
      rx_byte <= '0; cnt <= '0; lim <= '0; bitn <= '0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy <= 1'b1;
        sr   <= tx_byte;
        cnt  <= '0;
        bitn <= '0;
        sck  <= 1'b0;
        lim  <= (div == '0) ? DIV_W'(1) : div;
      end else if (busy) begin
        if (cnt == lim - DIV_W'(1)) begin
          cnt <= '0;
          if (!sck) begin
            sck     <= 1'b1;
            rx_byte <= {rx_byte[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sr   <= {sr[6:0], 1'b0};
            end
          end
        end else begin
          cnt <= cnt + DIV_W'(1);
        end
      end
    end
  end

  p_sck_idle_low_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);
  p_mosi_steady_high_r2: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));
  p_go_only_idle_r3: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy);
endmodule

// File: rtl/probe_seq.sv
module probe_seq
  import spi_probe_pkg::*;
#(
  parameter int         NBYTES    = 16,
  parameter int         DIV_W     = 8,
  parameter logic [7:0] STATUS_OP = 8'hD7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  input  logic             out_ready,
  input  logic             x_busy,
  input  logic             x_done,
  input  logic [7:0]       x_rx,
  output logic             x_go,
  output logic [7:0]       x_tx,
  output logic             cs_n,
  output logic             busy,
  output logic             type_valid,
  output dev_kind_t        type_code,
  output logic [1:0]       page_sel,
  output logic [7:0]       out_data,
  output logic             out_valid
);
  localparam int LEFT_W = $clog2(NBYTES + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_ADR, S_PROBE3, S_PROBE4, S_STREAM,
    S_GAP, S_STCMD, S_STRD, S_END
  } st_t;

  st_t              state;
  logic [DIV_W-1:0] lim, gap_cnt;
  logic             need, inflight, adr_n;
  logic [7:0]       tx_sel;
  logic [LEFT_W-1:0] left;

  always_comb begin
    lim    = (div == '0) ? DIV_W'(1) : div;
    need   = (state inside {S_CMD, S_ADR, S_PROBE3, S_PROBE4, S_STCMD, S_STRD}) ||
             (state == S_STREAM && !out_valid);
    tx_sel = (state == S_CMD) ? READ_OP : (state == S_STCMD) ? STATUS_OP : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; cs_n <= 1'b1; busy <= 1'b0; type_valid <= 1'b0;
      type_code <= DEV_NONE; page_sel <= 2'd0; out_data <= '0;
      out_valid <= 1'b0; x_go <= 1'b0; x_tx <= '0; inflight <= 1'b0;
      adr_n <= 1'b0; left <= '0; gap_cnt <= '0;
    end else begin
      x_go <= 1'b0;
      if (need && !inflight) begin
        x_go     <= 1'b1;
        x_tx     <= tx_sel;
        inflight <= 1'b1;
      end else if (x_done) begin
        inflight <= 1'b0;
      end

      case (state)
        S_IDLE: if (start) begin
          cs_n <= 1'b0; busy <= 1'b1; type_valid <= 1'b0;
          out_valid <= 1'b0; adr_n <= 1'b0; page_sel <= 2'd0;
          state <= S_CMD;
        end
        S_CMD: if (x_done) state <= S_ADR;
        S_ADR: if (x_done) begin
          if (adr_n) state <= S_PROBE3;
          adr_n <= 1'b1;
        end
        S_PROBE3: if (x_done) begin
          if (x_rx != FLOAT_VAL) begin
            type_code <= DEV_ADDR16;
            out_data  <= x_rx; out_valid <= 1'b1;
            left      <= LEFT_W'(NBYTES - 1);
            state     <= S_STREAM;
          end else state <= S_PROBE4;
        end
        S_PROBE4: if (x_done) begin
          if (x_rx != FLOAT_VAL) begin
            type_code <= DEV_ADDR24;
            out_data  <= x_rx; out_valid <= 1'b1;
            left      <= LEFT_W'(NBYTES - 1);
            state     <= S_STREAM;
          end else begin
            cs_n <= 1'b1; gap_cnt <= '0; state <= S_GAP;
          end
        end
        S_STREAM: begin
          if (out_valid) begin
            if (out_ready) begin
              out_valid <= 1'b0;
              if (left == '0) state <= S_END;
            end
          end else if (x_done) begin
            out_data  <= x_rx; out_valid <= 1'b1;
            left      <= left - LEFT_W'(1);
          end
        end
        S_GAP: begin
          if (gap_cnt == lim - DIV_W'(1)) begin
            cs_n <= 1'b0; state <= S_STCMD;
          end else gap_cnt <= gap_cnt + DIV_W'(1);
        end
        S_STCMD: if (x_done) state <= S_STRD;
        S_STRD: if (x_done) begin
          if (x_rx == FLOAT_VAL) begin
            type_code <= DEV_NONE; page_sel <= 2'd0;
          end else begin
            type_code <= DEV_PAGED; page_sel <= page_of(x_rx);
          end
          state <= S_END;
        end
        S_END: begin
          cs_n <= 1'b1; busy <= 1'b0; type_valid <= 1'b1; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_stall_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  p_result_after_busy_r9: assert property (@(posedge clk) disable iff (rst)
    type_valid |-> !busy);
  p_no_issue_inflight_r2: assert property (@(posedge clk) disable iff (rst)
    x_go |-> !x_busy);
endmodule

// File: rtl/spi_addr_probe.sv
module spi_addr_probe
  import spi_probe_pkg::*;
#(
  parameter int         DIV_W     = 8,
  parameter int         NBYTES    = 16,
  parameter logic [7:0] STATUS_OP = 8'hD7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] clk_div,
  output logic             spi_sck,
  output logic             spi_mosi,
  output logic             spi_cs_n,
  input  logic             spi_miso,
  output logic [1:0]       dev_type,
  output logic             dev_type_valid,
  output logic             busy,
  output logic [1:0]       page_sel,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready
);
  logic       x_go, x_busy, x_done;
  logic [7:0] x_tx, x_rx;
  dev_kind_t  kind;

  spi_shift_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst(rst), .go(x_go), .tx_byte(x_tx), .div(clk_div),
    .miso(spi_miso), .busy(x_busy), .done(x_done), .rx_byte(x_rx),
    .sck(spi_sck), .mosi(spi_mosi)
  );

  probe_seq #(.NBYTES(NBYTES), .DIV_W(DIV_W), .STATUS_OP(STATUS_OP)) u_seq (
    .clk(clk), .rst(rst), .start(start), .div(clk_div), .out_ready(rd_ready),
    .x_busy(x_busy), .x_done(x_done), .x_rx(x_rx), .x_go(x_go), .x_tx(x_tx),
    .cs_n(spi_cs_n), .busy(busy), .type_valid(dev_type_valid),
    .type_code(kind), .page_sel(page_sel), .out_data(rd_data),
    .out_valid(rd_valid)
  );

  assign dev_type = kind;

  p_cs_gates_sck_r6: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);
endmodule

// File: tb/tb_spi_addr_probe.sv
module tb_spi_addr_probe;
  localparam int DIV_W = 4;
  localparam int NB    = 4;

  logic clk = 0, rst = 1, start = 0, rd_ready = 0;
  logic [DIV_W-1:0] clk_div = 1;
  logic sck, mosi, cs_n, miso, busy, tvalid, rd_valid;
  logic [1:0] dev_type, page_sel;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  spi_addr_probe #(.DIV_W(DIV_W), .NBYTES(NB)) dut (
    .clk(clk), .rst(rst), .start(start), .clk_div(clk_div), .spi_sck(sck),
    .spi_mosi(mosi), .spi_cs_n(cs_n), .spi_miso(miso), .dev_type(dev_type),
    .dev_type_valid(tvalid), .busy(busy), .page_sel(page_sel),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready)
  );

  int checks = 0, fails = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // serial memory model: 0 two-byte, 1 three-byte, 2 paged, 3 absent
  int dev = 3;
  logic [7:0] status = 8'hFF;
  int k = 0, b = 0, tcnt = 0, tidx = 0;
  logic [7:0] sr = 0, cmd = 0;
  logic [7:0] cap [0:3][0:15];
  int nbytes [0:3];

  function automatic logic [7:0] memv(input int i);
    return 8'((i * 37 + 17) & 255);
  endfunction

  function automatic logic model_bit(input int kk, input int bb, input int dv,
                                     input logic [7:0] c, input logic [7:0] st);
    logic [7:0] v;
    v = 8'hFF;
    if (kk >= 1) begin
      if ((dv == 0 || dv == 1) && c == 8'h03 && kk >= 3 + dv) v = memv(kk - 3 - dv);
      if (dv == 2 && c == 8'hD7) v = st;
    end
    return v[7 - bb];
  endfunction

  assign miso = cs_n ? 1'b1 : model_bit(k, b, dev, cmd, status);

  always @(negedge cs_n) begin
    k = 0; b = 0; sr = 0; tidx = tcnt & 3; tcnt++; nbytes[tidx] = 0;
  end
  always @(posedge sck) if (!cs_n) begin
    sr = {sr[6:0], mosi}; b++;
    if (b == 8) begin
      if (k < 16) cap[tidx][k] = sr;
      if (k == 0) cmd = sr;
      k++; b = 0; nbytes[tidx] = k;
    end
  end

  // SCK high-phase and chip-select gap monitors
  int exp_half = 1, hi = 0, gap = 0, last_gap = 0;
  bit cs_seen = 0;
  always @(negedge clk) begin
    if (sck) hi++;
    else if (hi > 0) begin
      chk(hi == exp_half, "R3", "sck high cycles", hi, exp_half);
      hi = 0;
    end
    if (!cs_n) begin
      if (gap > 0) last_gap = gap;
      gap = 0; cs_seen = 1;
    end else if (busy && cs_seen) gap++;
  end

  // stream sink with optional stall
  int stall_len = 0, stall = 0, got = 0;
  logic [7:0] gotv [0:15];
  always @(negedge clk) begin
    if (rd_valid && !rd_ready) begin
      if (stall < stall_len) begin
        if (stall > 0) chk(rd_data == gotv[15] && sck == 1'b0, "R7",
                           "stall hold", int'(rd_data), int'(gotv[15]));
        gotv[15] = rd_data;
        stall++;
      end else begin
        if (got < 15) gotv[got] = rd_data;
        got++;
        rd_ready = 1;
      end
    end else if (rd_ready) begin
      rd_ready = 0; stall = 0;
    end
  end

  bit hung = 0;
  task automatic run(input int dv, input int dvd, input logic [7:0] st,
                     input int stl, input bit poke);
    int cyc;
    int exp_t, exp_p, half;
    if (hung) return;
    dev = dv; status = st; clk_div = DIV_W'(dvd); stall_len = stl;
    half = (dvd == 0) ? 1 : dvd; exp_half = half;
    got = 0; tcnt = 0; cs_seen = 0; last_gap = 0; stall = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    cyc = 0;
    while (!tvalid) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) start = 1;
      if (poke && cyc == 41) start = 0;
      if (cyc > 20000) begin
        hung = 1;
        chk(0, "R6", "watchdog expired", cyc, 0);
        return;
      end
    end
    exp_t = (dv == 0) ? 0 : (dv == 1) ? 1 : (dv == 2 && st != 8'hFF) ? 2 : 3;
    exp_p = (exp_t == 2) ? ((st[5:2] <= 4) ? 0 : (st[5:2] == 5) ? 1 : 2) : 0;
    chk(dev_type == 2'(exp_t), (dv == 0) ? "R4" : (dv == 1) ? "R5" : "R9",
        "dev_type", dev_type, exp_t);
    chk(cs_n && !busy, "R6", "cs high and idle at result", cs_n, 1);
    chk(cap[0][0] == 8'h03, "R2", "first opcode", cap[0][0], 3);
    for (int i = 1; i < nbytes[0] && i < 16; i++)
      chk(cap[0][i] == 8'h00, "R2", "zero byte", cap[0][i], 0);
    if (dv <= 1) begin
      chk(tcnt == 1, "R10", "transaction count", tcnt, 1);
      chk(nbytes[0] == 3 + dv + NB, "R6", "bytes in window", nbytes[0], 3 + dv + NB);
      chk(got == NB, "R6", "stream length", got, NB);
      for (int i = 0; i < NB && i < got; i++)
        chk(gotv[i] == memv(i), (dv == 0) ? "R4" : "R5", "stream byte",
            gotv[i], memv(i));
    end else begin
      chk(tcnt == 2, "R10", "transaction count", tcnt, 2);
      chk(nbytes[0] == 5, "R8", "probe bytes", nbytes[0], 5);
      chk(last_gap == half, "R8", "cs gap cycles", last_gap, half);
      chk(cap[1][0] == 8'hD7 && cap[1][1] == 8'h00 && nbytes[1] == 2, "R8",
          "status command", cap[1][0], 8'hD7);
      chk(page_sel == 2'(exp_p), (exp_t == 2) ? "R8" : "R9", "page_sel",
          page_sel, exp_p);
      chk(got == 0, "R9", "no stream for paged path", got, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1 && sck == 0 && !busy && !tvalid && !rd_valid, "R1",
        "reset state", {cs_n, sck, busy, tvalid, rd_valid}, 5'b10000);
    rst = 0;
    @(negedge clk);
    chk(cs_n == 1 && !busy, "R1", "idle after reset", cs_n, 1);
    for (int d = 0; d < 4; d++) begin
      run(0, d, 8'hFF, (d == 2) ? 5 : 0, d == 3);
      run(1, d, 8'hFF, (d == 2) ? 5 : 0, d == 3);
      run(3, d, 8'hFF, 0, d == 3);
      run(2, d, 8'h94, 0, 0);
    end
    for (int f = 0; f < 16; f++) run(2, 1, {2'b10, 4'(f), 2'b00}, 0, 0);
    run(2, 2, 8'hFF, 0, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule